// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Interrupt Detection

This block is one port of general-purpose I/O pins behind a simple memory-mapped register bus. Every pin has its own 32-byte register window. The window sets whether the pin is enabled, whether it drives or senses, and how it raises an interrupt. A pin can trigger on an active level, on a single edge of chosen polarity, or on either edge. The window also holds the output level, an output-control gate, a debounce threshold and a write-only interrupt-clear register.

Pad inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. Each pin holds a pending flag. A port-wide status word collects the pending flags one bit per pin, whatever their mask state. A single registered interrupt line is the OR of the pending flags of pins that are both enabled and unmasked. Debounce is reduced to a stored enable and threshold that do not delay detection. Bus reads return data one cycle after the request.

Top module: `gpio_port_irq`

## Requirements
- R1: Pin n owns byte addresses n*0x20 to n*0x20+0x1F, with configuration at +0x00, debounce threshold at +0x04, input view at +0x08, output control at +0x0C, output value at +0x10 and interrupt clear at +0x14. Configuration reads back bits 6:0 of the last write, the threshold reads back all 32 bits, output control and output value read back bit 0, and the clear register and unmapped offsets read as 0. Read data appears on the clock edge after the request and is 0 when there is no read.
- R2: After synchronous reset, all registers, pending flags, read data, pad_oe, pad_out and irq_out are 0.
- R3: pad_oe[n] is 1 exactly when configuration bit 1 (1 = output) is set and output-control bit 0 is 0. pad_out[n] follows output-value bit 0. Both are registered and change one cycle after the register write.
- R4: Bit 0 of the input view returns the output-value bit when configuration bit 1 is set. Otherwise it returns the pad after the two-flop synchroniser.
- R5: Trigger type is configuration bits 3:2. Type 1 is level trigger: polarity bit 4 = 1 means active high and 0 means active low. The pending flag is set on every cycle the synchronised level is active, so a clear write does not remove it while the level persists.
- R6: Type 2 is single-edge trigger: bit 4 = 1 selects rising and 0 selects falling. The pending flag stays set until it is cleared.
- R7: Type 3 detects both edges, and bit 4 has no effect.
- R8: Type 0 never sets the pending flag.
- R9: A write to +0x14 with bit 0 = 1 clears that pin's pending flag, and a write with bit 0 = 0 has no effect. A detection in the same cycle as a clear wins, so the flag stays set.
- R10: The status word at byte address 0x104 shows the pending flag of pin n in bit n, whatever the state of the interrupt-enable bit.
- R11: irq_out is registered and goes high one cycle after any pin has its pending flag, configuration bit 0 (pin enable) and configuration bit 6 (interrupt enable) all set.
- R12: Debounce enable (configuration bit 5) and the threshold value do not delay or suppress detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Pad drive enables |
| pad_out | output | 8 | Pad drive levels |
| irq_out | output | 1 | Combined port interrupt |

## Verification
The functions most likely to collide are a software clear of a pin's pending flag and a new detection on the same pin in the same clock. The bench provokes this by toggling a both-edge pin two clock periods before it issues the clear write, so the synchronised edge and the clear land on the same edge. It judges the result by the status bit, which must stay set, and by a behavioural reference model that compares every output on every clock. A level-triggered pin being cleared while its level is still active is exercised the same way.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // Field order gives the bit positions: pin_en is bit 0, irq_en is bit 6.
  typedef struct packed {
    logic  irq_en;
    logic  dbc_en;
    logic  pol_hi;
    trig_e trig;
    logic  dir_out;
    logic  pin_en;
  } pin_cfg_t;

  localparam int CFG_W    = $bits(pin_cfg_t);
  localparam int WIN_BITS = 5;

  localparam logic [WIN_BITS-1:0] OFF_CFG  = 5'h00;
  localparam logic [WIN_BITS-1:0] OFF_DBC  = 5'h04;
  localparam logic [WIN_BITS-1:0] OFF_IN   = 5'h08;
  localparam logic [WIN_BITS-1:0] OFF_OCTL = 5'h0C;
  localparam logic [WIN_BITS-1:0] OFF_OVAL = 5'h10;
  localparam logic [WIN_BITS-1:0] OFF_CLR  = 5'h14;

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
module gpio_pin_cell
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic              wr_cfg,
  input  logic              wr_dbc,
  input  logic              wr_octl,
  input  logic              wr_oval,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output pin_cfg_t          cfg,
  output logic [DATA_W-1:0] dbc_thr,
  output logic              octl,
  output logic              oval,
  output logic              pend,
  output logic              in_view
);
  logic prev_q;
  logic hit;
  logic clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      dbc_thr <= '0;
      octl    <= 1'b0;
      oval    <= 1'b0;
      prev_q  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (wr_cfg)  cfg     <= pin_cfg_t'(wdata[CFG_W-1:0]);
      if (wr_dbc)  dbc_thr <= wdata;
      if (wr_octl) octl    <= wdata[0];
      if (wr_oval) oval    <= wdata[0];
      prev_q <= sync_in;
      // Detection has priority over a clear in the same cycle.
      pend   <= (pend & ~clr) | hit;
    end
  end

  always_comb begin
    case (cfg.trig)
      TRIG_LEVEL: hit = (sync_in == cfg.pol_hi);
      TRIG_EDGE:  hit = cfg.pol_hi ? (sync_in & ~prev_q) : (~sync_in & prev_q);
      TRIG_BOTH:  hit = sync_in ^ prev_q;
      default:    hit = 1'b0;
    endcase
  end

  assign clr     = wr_clr & wdata[0];
  assign in_view = cfg.dir_out ? oval : sync_in;
endmodule

// File: rtl/gpio_port_irq.sv
`timescale 1ns/1ps
module gpio_port_irq
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 9'h104
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic              irq_out
);
  localparam int PIN_W     = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int WIN_LIMIT = NPINS << WIN_BITS;

  logic [NPINS-1:0]    sync_q;
  pin_cfg_t            cfg_a [NPINS];
  logic [DATA_W-1:0]   thr_a [NPINS];
  logic [NPINS-1:0]    octl_v, oval_v, pend_q, view_v;
  logic [NPINS-1:0]    en_v, ie_v, dir_v, clr_v;
  logic                wr_en, rd_en, in_win;
  logic [PIN_W-1:0]    pin_sel;
  logic [WIN_BITS-1:0] off;
  logic [DATA_W-1:0]   rd_word;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
  );

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign in_win  = (bus_addr < ADDR_W'(WIN_LIMIT));
  assign pin_sel = bus_addr[WIN_BITS +: PIN_W];
  assign off     = bus_addr[WIN_BITS-1:0];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam logic [PIN_W-1:0] PID = PIN_W'(p);
    logic sel_p;
    assign sel_p    = wr_en & in_win & (pin_sel == PID);
    assign clr_v[p] = sel_p & (off == OFF_CLR);

    gpio_pin_cell #(.DATA_W(DATA_W)) cell_i (
      .clk     (clk),
      .rst     (rst),
      .sync_in (sync_q[p]),
      .wr_cfg  (sel_p & (off == OFF_CFG)),
      .wr_dbc  (sel_p & (off == OFF_DBC)),
      .wr_octl (sel_p & (off == OFF_OCTL)),
      .wr_oval (sel_p & (off == OFF_OVAL)),
      .wr_clr  (clr_v[p]),
      .wdata   (bus_wdata),
      .cfg     (cfg_a[p]),
      .dbc_thr (thr_a[p]),
      .octl    (octl_v[p]),
      .oval    (oval_v[p]),
      .pend    (pend_q[p]),
      .in_view (view_v[p])
    );

    assign en_v[p]  = cfg_a[p].pin_en;
    assign ie_v[p]  = cfg_a[p].irq_en;
    assign dir_v[p] = cfg_a[p].dir_out;
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == STATUS_ADDR) begin
      rd_word[NPINS-1:0] = pend_q;
    end else if (in_win) begin
      case (off)
        OFF_CFG:  rd_word[CFG_W-1:0] = cfg_a[pin_sel];
        OFF_DBC:  rd_word            = thr_a[pin_sel];
        OFF_IN:   rd_word[0]         = view_v[pin_sel];
        OFF_OCTL: rd_word[0]         = octl_v[pin_sel];
        OFF_OVAL: rd_word[0]         = oval_v[pin_sel];
        default:  rd_word            = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pad_oe    <= '0;
      pad_out   <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_en ? rd_word : '0;
      pad_oe    <= dir_v & ~octl_v;
      pad_out   <= oval_v;
      irq_out   <= |(pend_q & en_v & ie_v);
    end
  end
endmodule

// File: rtl/gpio_port_irq_chk.sv
`timescale 1ns/1ps
module gpio_port_irq_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] clr,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] ie,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] octl
);
  assert_irq_quiet_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_out);

  assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(pend & en & ie)));

  assert_irq_follows_source_R11: assert property (@(posedge clk) disable iff (rst)
    (|(pend & en & ie)) |=> irq_out);

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_pend_held_R6: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !clr[i]) |=> pend[i]);

    assert_drive_gated_R3: assert property (@(posedge clk) disable iff (rst)
      pad_oe[i] |-> $past(dir[i] && !octl[i]));
  end
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst(rst), .irq_out(irq_out), .pad_oe(pad_oe), .pend(pend_q),
  .clr(clr_v), .en(en_v), .ie(ie_v), .dir(dir_v), .octl(octl_v)
);

// File: tb/gpio_port_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_port_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe, pad_out;
  logic        irq_out;

  int n_cmp = 0, n_bad = 0;
  bit chk_on = 0, done = 0;

  always #2.5 clk = ~clk;

  gpio_port_irq dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [6:0]  m_cfg [8];
  logic [31:0] m_thr [8];
  logic [7:0]  m_octl, m_oval, m_s1, m_s2, m_prev, m_pend, m_oe, m_out;
  logic        m_irq;
  logic [31:0] m_rd;

  function automatic logic mhit(input int i);
    logic cur, pv, pol;
    cur = m_s2[i]; pv = m_prev[i]; pol = m_cfg[i][4];
    case (m_cfg[i][3:2])
      2'd1:    return cur == pol;
      2'd2:    return pol ? (cur && !pv) : (!cur && pv);
      2'd3:    return cur != pv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mread(input logic [8:0] a);
    int pin, o;
    if (a == 9'h104) return {24'd0, m_pend};
    if (a >= 9'd256) return 32'd0;
    pin = int'(a) / 32; o = int'(a) % 32;
    case (o)
      0:  return {25'd0, m_cfg[pin]};
      4:  return m_thr[pin];
      8:  return {31'd0, m_cfg[pin][1] ? m_oval[pin] : m_s2[pin]};
      12: return {31'd0, m_octl[pin]};
      16: return {31'd0, m_oval[pin]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] n_pend, n_oe, n_out;
    logic n_irq, clr;
    logic [31:0] n_rd;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_cfg[i] = '0; m_thr[i] = '0; end
      m_octl = 0; m_oval = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
      m_oe = 0; m_out = 0; m_irq = 0; m_rd = 0;
    end else begin
      n_rd = (bus_sel && !bus_wr) ? mread(bus_addr) : 32'd0;
      n_irq = 0;
      for (int i = 0; i < 8; i++) begin
        if (m_pend[i] && m_cfg[i][0] && m_cfg[i][6]) n_irq = 1;
        n_oe[i]  = m_cfg[i][1] && !m_octl[i];
        n_out[i] = m_oval[i];
        clr = bus_sel && bus_wr && (int'(bus_addr) == i*32 + 20) && bus_wdata[0];
        n_pend[i] = (m_pend[i] && !clr) || mhit(i);
      end
      if (bus_sel && bus_wr && bus_addr < 9'd256) begin
        case (int'(bus_addr) % 32)
          0:  m_cfg[int'(bus_addr)/32]  = bus_wdata[6:0];
          4:  m_thr[int'(bus_addr)/32]  = bus_wdata;
          12: m_octl[int'(bus_addr)/32] = bus_wdata[0];
          16: m_oval[int'(bus_addr)/32] = bus_wdata[0];
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      m_pend = n_pend; m_oe = n_oe; m_out = n_out; m_irq = n_irq; m_rd = n_rd;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(bus_rdata, m_rd, "R1 R4 R10 model rdata");
      check({24'd0, pad_oe}, {24'd0, m_oe}, "R3 model pad_oe");
      check({24'd0, pad_out}, {24'd0, m_out}, "R3 model pad_out");
      check({31'd0, irq_out}, {31'd0, m_irq}, "R11 model irq_out");
    end
  end

  // ---------------- stimulus helpers (start and end at a negedge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] mask,
                        input logic [31:0] exp, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    check(bus_rdata & mask, exp, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    chk_on = 1;
    // R2 reset state
    check({31'd0, irq_out}, 32'd0, "R2 irq_out after reset");
    check({24'd0, pad_oe}, 32'd0, "R2 pad_oe after reset");
    rd_chk(9'h000, 32'hFFFF_FFFF, 32'h0, "R2 cfg pin0");
    rd_chk(9'h104, 32'hFFFF_FFFF, 32'h0, "R2 status");

    // R1 register window map
    wr(9'h060, 32'h23);
    rd_chk(9'h060, 32'hFFFF_FFFF, 32'h23, "R1 cfg readback");
    wr(9'h064, 32'hABCD_1234);
    rd_chk(9'h064, 32'hFFFF_FFFF, 32'hABCD_1234, "R1 threshold readback");
    wr(9'h06C, 32'h1);
    rd_chk(9'h06C, 32'hFFFF_FFFF, 32'h1, "R1 output control readback");
    rd_chk(9'h074, 32'hFFFF_FFFF, 32'h0, "R1 clear reads zero");
    rd_chk(9'h078, 32'hFFFF_FFFF, 32'h0, "R1 unmapped reads zero");
    wr(9'h060, 32'hFFFF_FF80);
    rd_chk(9'h060, 32'hFFFF_FFFF, 32'h0, "R1 cfg upper bits dropped");

    // R3 pad drive
    wr(9'h060, 32'h03);
    idle(2);
    check({31'd0, pad_oe[3]}, 32'd0, "R3 oe blocked by output control");
    wr(9'h06C, 32'h0);
    idle(1);
    check({31'd0, pad_oe[3]}, 32'd1, "R3 oe on");
    wr(9'h070, 32'h1);
    idle(1);
    check({31'd0, pad_out[3]}, 32'd1, "R3 pad_out level");

    // R4 input view
    rd_chk(9'h068, 32'h1, 32'h1, "R4 output pin reads output value");
    wr(9'h060, 32'h01);
    idle(1);
    check({31'd0, pad_oe[3]}, 32'd0, "R3 oe off for input");
    rd_chk(9'h068, 32'h1, 32'h0, "R4 input pin reads pad");
    wr(9'h040, 32'h01);
    pad_in[2] = 1;
    idle(3);
    rd_chk(9'h048, 32'h1, 32'h1, "R4 synchronised pad high");

    // R5 level trigger, active high then low
    wr(9'h080, 32'h55);
    pad_in[4] = 1;
    idle(5);
    rd_chk(9'h104, 32'h10, 32'h10, "R5 level high pending");
    check({31'd0, irq_out}, 32'd1, "R11 irq from level pin");
    wr(9'h094, 32'h1);
    idle(1);
    rd_chk(9'h104, 32'h10, 32'h10, "R5 level persists through clear");
    pad_in[4] = 0;
    idle(4);
    wr(9'h094, 32'h1);
    idle(1);
    rd_chk(9'h104, 32'h10, 32'h0, "R5 cleared once inactive");
    idle(2);
    check({31'd0, irq_out}, 32'd0, "R11 irq drops");
    wr(9'h080, 32'h45);
    idle(3);
    rd_chk(9'h104, 32'h10, 32'h10, "R5 active low pending");
    wr(9'h080, 32'h00);
    wr(9'h094, 32'h1);
    rd_chk(9'h104, 32'h10, 32'h0, "R5 low level cleared");

    // R6 single edge
    wr(9'h0A0, 32'h59);
    pad_in[5] = 1;
    idle(4);
    rd_chk(9'h104, 32'h20, 32'h20, "R6 rising edge pending");
    pad_in[5] = 0;
    idle(4);
    rd_chk(9'h104, 32'h20, 32'h20, "R6 pending held");
    wr(9'h0B4, 32'h0);
    rd_chk(9'h104, 32'h20, 32'h20, "R9 clear with bit0 zero ignored");
    wr(9'h0B4, 32'h1);
    rd_chk(9'h104, 32'h20, 32'h0, "R9 clear");
    wr(9'h0A0, 32'h49);
    pad_in[5] = 1;
    idle(4);
    rd_chk(9'h104, 32'h20, 32'h0, "R6 rising ignored in falling mode");
    pad_in[5] = 0;
    idle(4);
    rd_chk(9'h104, 32'h20, 32'h20, "R6 falling edge pending");
    wr(9'h0B4, 32'h1);

    // R7 both edges, polarity ignored
    wr(9'h0C0, 32'h4D);
    pad_in[6] = 1;
    idle(4);
    rd_chk(9'h104, 32'h40, 32'h40, "R7 rise detected");
    wr(9'h0D4, 32'h1);
    pad_in[6] = 0;
    idle(4);
    rd_chk(9'h104, 32'h40, 32'h40, "R7 fall detected");
    wr(9'h0D4, 32'h1);
    wr(9'h0C0, 32'h5D);
    pad_in[6] = 1;
    idle(4);
    rd_chk(9'h104, 32'h40, 32'h40, "R7 polarity bit ignored");

    // R9 collision: new edge and clear on the same clock edge
    pad_in[6] = 0;
    idle(2);
    wr(9'h0D4, 32'h1);
    rd_chk(9'h104, 32'h40, 32'h40, "R9 detection wins over clear");
    wr(9'h0D4, 32'h1);
    rd_chk(9'h104, 32'h40, 32'h0, "R9 later clear");

    // R8 type zero
    wr(9'h0E0, 32'h41);
    pad_in[7] = 1;
    idle(4);
    pad_in[7] = 0;
    idle(4);
    rd_chk(9'h104, 32'h80, 32'h0, "R8 no detection");

    // R10 / R11 masking
    wr(9'h0A0, 32'h19);
    pad_in[5] = 1;
    idle(5);
    rd_chk(9'h104, 32'h20, 32'h20, "R10 masked pin visible in status");
    check({31'd0, irq_out}, 32'd0, "R11 masked pin no irq");
    wr(9'h0A0, 32'h59);
    idle(2);
    check({31'd0, irq_out}, 32'd1, "R11 unmask raises irq");
    wr(9'h0A0, 32'h58);
    idle(2);
    check({31'd0, irq_out}, 32'd0, "R11 disabled pin no irq");
    wr(9'h0B4, 32'h1);
    pad_in[5] = 0;
    wr(9'h0A0, 32'h00);

    // R12 debounce pass-through
    wr(9'h044, 32'hFFFF_FFFF);
    wr(9'h040, 32'h69);
    pad_in[2] = 0;
    idle(4);
    rd_chk(9'h104, 32'h04, 32'h04, "R12 debounce does not delay");
    idle(1);
    check({31'd0, irq_out}, 32'd1, "R12 irq with debounce set");
    wr(9'h054, 32'h1);
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule